// File: doc/BRIEF.md
# Message Object Staging Transfer Engine

This block is the processor-side window onto a bank of CAN message objects held in internal storage. Software never touches an object directly. It fills a set of 16-bit staging registers (acceptance mask, arbitration word, message control and eight data bytes), writes a command mask that picks the groups to move and the direction, and then writes an object number into the request register. The engine moves the chosen groups between the staging registers and the selected object. While it does so it raises a busy flag. When software reads an object, the engine can also clear that object's pending and new-data flags. When software writes an object, it can also post a transmit request.

Three summary vectors are kept as live outputs: transmit request, new data and interrupt pending. Each has one bit per object. Acceptance filtering and the bus side are not part of this block.

The sequencer has three states. In `ST_IDLE` it waits, and a valid request moves it to `ST_FETCH`. In `ST_FETCH` it latches the addressed object, with its live flags, into a holding register, then always moves to `ST_COMMIT`. In `ST_COMMIT` it performs the write into the object or the copy into staging, applies any flag side effects, and always returns to `ST_IDLE`. Busy is high in `ST_FETCH` and `ST_COMMIT`.

Top module: `msgif_engine`

## Requirements
- R1: Writing a value from 1 to NUM_OBJ (32) to the request register while idle starts a transfer. From the next cycle, `busy` and bit 15 of the request register read high. The transfer completes, with `busy` low again, within 6 clocks.
- R2: Writing 0 or any value above NUM_OBJ to the request register is ignored. No busy is raised, no object or flag changes, and the request register keeps its previous object number.
- R3: A request written while a transfer is in progress is ignored. The request register's low bits keep the number that was accepted, and the other object is not touched.
- R4: If command-mask bit 7 is 1 (write), each selected group is copied from staging into the object and every unselected group of the object is unchanged. The group selects are bit 6 = mask, bit 5 = arbitration, bit 4 = control, bit 1 = data bytes 0-3 and bit 0 = data bytes 4-7.
- R5: If command-mask bit 7 is 0 (read), each selected group is copied from the object into staging, and unselected staging registers keep their values.
- R6: A write with command-mask bit 2 set sets the object's transmit-request and new-data flags. This applies whether or not the control group is selected, and it overrides the control copy.
- R7: A read with command-mask bit 3 set clears the object's interrupt-pending flag. A read with bit 2 set clears its new-data flag. The control value copied to staging shows the flags as they were before the clear.
- R8: Bit n-1 of `txrq_vec`, `newdat_vec` and `intpnd_vec` belongs to object n. A write with the control group selected loads these flags from message-control bits 8 (transmit request), 15 (new data) and 13 (interrupt pending). A read of the control group returns them in the same bit positions.
- R9: After reset, `busy` is low, all summary vectors and staging registers are zero, the request register reads zero and every object holds zeros.
- R10: Register addresses are 0 request, 1 command mask (bits 7:0), 2/3 mask low/high, 4/5 arbitration low/high, 6 message control, and 7, 8, 9, 10 data words. Data word k holds byte 2k in bits 7:0 and byte 2k+1 in bits 15:8. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| busy | output | 1 | Transfer in progress |
| txrq_vec | output | NUM_OBJ | Transmit-request flag per object |
| newdat_vec | output | NUM_OBJ | New-data flag per object |
| intpnd_vec | output | NUM_OBJ | Interrupt-pending flag per object |

## Verification
A wrong sequencer state shows at once on `busy` and on bit 15 of the request register. It appears as a transfer that never ends, ends too early, or restarts on a second request. A wrong latched object index or command snapshot stays hidden until a later full read of that object or of a neighbour returns the wrong group contents. Exhaustive sweeps over all 32 group selections in both directions, followed by full read-backs, expose such a fault within one or two transfers. Flag errors appear on the summary vectors in the cycle after busy falls.

// File: rtl/msgif_pkg.sv
package msgif_pkg;
    localparam int ADDR_W = 4;
    localparam int REG_W  = 16;

    localparam logic [ADDR_W-1:0] A_REQ    = 4'd0;
    localparam logic [ADDR_W-1:0] A_CMASK  = 4'd1;
    localparam logic [ADDR_W-1:0] A_MASK_L = 4'd2;
    localparam logic [ADDR_W-1:0] A_MASK_H = 4'd3;
    localparam logic [ADDR_W-1:0] A_ARB_L  = 4'd4;
    localparam logic [ADDR_W-1:0] A_ARB_H  = 4'd5;
    localparam logic [ADDR_W-1:0] A_MCTL   = 4'd6;
    localparam logic [ADDR_W-1:0] A_DAT0   = 4'd7;
    localparam logic [ADDR_W-1:0] A_DAT1   = 4'd8;
    localparam logic [ADDR_W-1:0] A_DAT2   = 4'd9;
    localparam logic [ADDR_W-1:0] A_DAT3   = 4'd10;

    // command mask bit positions
    localparam int CM_DIR   = 7;
    localparam int CM_MASK  = 6;
    localparam int CM_ARB   = 5;
    localparam int CM_CTRL  = 4;
    localparam int CM_CLRIP = 3;
    localparam int CM_TXND  = 2;
    localparam int CM_DLO   = 1;
    localparam int CM_DHI   = 0;

    // message control flag positions
    localparam int MC_ND = 15;
    localparam int MC_IP = 13;
    localparam int MC_TX = 8;
    localparam logic [REG_W-1:0] MC_FLAGS = 16'hA100;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_COMMIT
    } xfer_state_t;
endpackage

// File: rtl/msgif_ctrl.sv
module msgif_ctrl
    import msgif_pkg::*;
#(
    parameter int NUM_OBJ = 32,
    localparam int IDX_W = $clog2(NUM_OBJ),
    localparam int NUM_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_wr,
    input  logic [REG_W-1:0] req_val,
    input  logic [7:0]       cmask_in,
    output logic             busy,
    output logic             load,
    output logic             commit,
    output logic [IDX_W-1:0] obj_idx,
    output logic [NUM_W-1:0] obj_num,
    output logic [7:0]       cmd
);
    xfer_state_t state, nxt;
    logic        accept;

    assign accept = req_wr && (state == ST_IDLE) &&
                    (req_val >= 16'd1) && (req_val <= 16'(NUM_OBJ));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            obj_idx <= '0;
            obj_num <= '0;
            cmd     <= '0;
        end else if (accept) begin
            obj_idx <= IDX_W'(req_val - 16'd1);
            obj_num <= req_val[NUM_W-1:0];
            cmd     <= cmask_in;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (accept) nxt = ST_FETCH;
            ST_FETCH:  nxt = ST_COMMIT;
            ST_COMMIT: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        busy   = (state != ST_IDLE);
        load   = (state == ST_FETCH);
        commit = (state == ST_COMMIT);
    end
endmodule

// File: rtl/msgif_store.sv
module msgif_store
    import msgif_pkg::*;
#(
    parameter int NUM_OBJ = 32,
    localparam int IDX_W = $clog2(NUM_OBJ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               commit,
    input  logic [IDX_W-1:0]   idx,
    input  logic [7:0]         cmd,
    input  logic [31:0]        st_mask,
    input  logic [31:0]        st_arb,
    input  logic [REG_W-1:0]   st_mctl,
    input  logic [63:0]        st_data,
    output logic [31:0]        hd_mask,
    output logic [31:0]        hd_arb,
    output logic [REG_W-1:0]   hd_mctl,
    output logic [63:0]        hd_data,
    output logic [NUM_OBJ-1:0] tx_vec,
    output logic [NUM_OBJ-1:0] nd_vec,
    output logic [NUM_OBJ-1:0] ip_vec
);
    logic [31:0]      mem_mask [NUM_OBJ];
    logic [31:0]      mem_arb  [NUM_OBJ];
    logic [REG_W-1:0] mem_mctl [NUM_OBJ];
    logic [63:0]      mem_data [NUM_OBJ];
    logic             wr_dir;
    logic [REG_W-1:0] live_flags;

    assign wr_dir = cmd[CM_DIR];
    assign live_flags = (REG_W'(nd_vec[idx]) << MC_ND) |
                        (REG_W'(ip_vec[idx]) << MC_IP) |
                        (REG_W'(tx_vec[idx]) << MC_TX);

    // object storage: written only by a write-direction commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_OBJ; i++) begin
                mem_mask[i] <= '0;
                mem_arb[i]  <= '0;
                mem_mctl[i] <= '0;
                mem_data[i] <= '0;
            end
        end else if (commit && wr_dir) begin
            if (cmd[CM_MASK]) mem_mask[idx] <= st_mask;
            if (cmd[CM_ARB])  mem_arb[idx]  <= st_arb;
            if (cmd[CM_CTRL]) mem_mctl[idx] <= st_mctl;
            if (cmd[CM_DLO])  mem_data[idx][31:0]  <= st_data[31:0];
            if (cmd[CM_DHI])  mem_data[idx][63:32] <= st_data[63:32];
        end
    end

    // holding register: snapshot of the object with its live flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hd_mask <= '0;
            hd_arb  <= '0;
            hd_mctl <= '0;
            hd_data <= '0;
        end else if (load) begin
            hd_mask <= mem_mask[idx];
            hd_arb  <= mem_arb[idx];
            hd_mctl <= (mem_mctl[idx] & ~MC_FLAGS) | live_flags;
            hd_data <= mem_data[idx];
        end
    end

    // per-object flags kept as flat vectors
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_vec <= '0;
            nd_vec <= '0;
            ip_vec <= '0;
        end else if (commit) begin
            if (wr_dir) begin
                if (cmd[CM_CTRL]) begin
                    tx_vec[idx] <= st_mctl[MC_TX];
                    nd_vec[idx] <= st_mctl[MC_ND];
                    ip_vec[idx] <= st_mctl[MC_IP];
                end
                if (cmd[CM_TXND]) begin
                    tx_vec[idx] <= 1'b1;
                    nd_vec[idx] <= 1'b1;
                end
            end else begin
                if (cmd[CM_CLRIP]) ip_vec[idx] <= 1'b0;
                if (cmd[CM_TXND])  nd_vec[idx] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/msgif_regs.sv
module msgif_regs
    import msgif_pkg::*;
#(
    parameter int NUM_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              busy,
    input  logic [NUM_W-1:0]  obj_num,
    input  logic [4:0]        grp_load,
    input  logic [31:0]       hd_mask,
    input  logic [31:0]       hd_arb,
    input  logic [REG_W-1:0]  hd_mctl,
    input  logic [63:0]       hd_data,
    output logic [31:0]       st_mask,
    output logic [31:0]       st_arb,
    output logic [REG_W-1:0]  st_mctl,
    output logic [63:0]       st_data,
    output logic [7:0]        cmask
);
    // grp_load order: {mask, arb, ctrl, data lo, data hi}
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_mask <= '0;
            st_arb  <= '0;
            st_mctl <= '0;
            st_data <= '0;
            cmask   <= '0;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    A_CMASK:  cmask          <= wr_data[7:0];
                    A_MASK_L: st_mask[15:0]  <= wr_data;
                    A_MASK_H: st_mask[31:16] <= wr_data;
                    A_ARB_L:  st_arb[15:0]   <= wr_data;
                    A_ARB_H:  st_arb[31:16]  <= wr_data;
                    A_MCTL:   st_mctl        <= wr_data;
                    A_DAT0:   st_data[15:0]  <= wr_data;
                    A_DAT1:   st_data[31:16] <= wr_data;
                    A_DAT2:   st_data[47:32] <= wr_data;
                    A_DAT3:   st_data[63:48] <= wr_data;
                    default:  ;
                endcase
            end
            if (grp_load[4]) st_mask <= hd_mask;
            if (grp_load[3]) st_arb  <= hd_arb;
            if (grp_load[2]) st_mctl <= hd_mctl;
            if (grp_load[1]) st_data[31:0]  <= hd_data[31:0];
            if (grp_load[0]) st_data[63:32] <= hd_data[63:32];
        end
    end

    always_comb begin
        case (rd_addr)
            A_REQ:    rd_data = {busy, {(REG_W-1-NUM_W){1'b0}}, obj_num};
            A_CMASK:  rd_data = {8'h00, cmask};
            A_MASK_L: rd_data = st_mask[15:0];
            A_MASK_H: rd_data = st_mask[31:16];
            A_ARB_L:  rd_data = st_arb[15:0];
            A_ARB_H:  rd_data = st_arb[31:16];
            A_MCTL:   rd_data = st_mctl;
            A_DAT0:   rd_data = st_data[15:0];
            A_DAT1:   rd_data = st_data[31:16];
            A_DAT2:   rd_data = st_data[47:32];
            A_DAT3:   rd_data = st_data[63:48];
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/msgif_engine.sv
module msgif_engine
    import msgif_pkg::*;
#(
    parameter int NUM_OBJ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [3:0]         wr_addr,
    input  logic [15:0]        wr_data,
    input  logic [3:0]         rd_addr,
    output logic [15:0]        rd_data,
    output logic               busy,
    output logic [NUM_OBJ-1:0] txrq_vec,
    output logic [NUM_OBJ-1:0] newdat_vec,
    output logic [NUM_OBJ-1:0] intpnd_vec
);
    localparam int IDX_W = $clog2(NUM_OBJ);
    localparam int NUM_W = IDX_W + 1;

    logic             load, commit, req_wr;
    logic [IDX_W-1:0] obj_idx;
    logic [NUM_W-1:0] obj_num;
    logic [7:0]       cmd, cmask;
    logic [4:0]       grp_load;
    logic [31:0]      st_mask, st_arb, hd_mask, hd_arb;
    logic [REG_W-1:0] st_mctl, hd_mctl;
    logic [63:0]      st_data, hd_data;

    assign req_wr   = wr_en && (wr_addr == A_REQ);
    assign grp_load = {5{commit & ~cmd[CM_DIR]}} &
                      {cmd[CM_MASK], cmd[CM_ARB], cmd[CM_CTRL], cmd[CM_DLO], cmd[CM_DHI]};

    msgif_ctrl #(.NUM_OBJ(NUM_OBJ)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_val(wr_data),
        .cmask_in(cmask), .busy(busy), .load(load), .commit(commit),
        .obj_idx(obj_idx), .obj_num(obj_num), .cmd(cmd)
    );

    msgif_regs #(.NUM_W(NUM_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .obj_num(obj_num), .grp_load(grp_load),
        .hd_mask(hd_mask), .hd_arb(hd_arb), .hd_mctl(hd_mctl), .hd_data(hd_data),
        .st_mask(st_mask), .st_arb(st_arb), .st_mctl(st_mctl), .st_data(st_data),
        .cmask(cmask)
    );

    msgif_store #(.NUM_OBJ(NUM_OBJ)) u_store (
        .clk(clk), .rst_n(rst_n), .load(load), .commit(commit),
        .idx(obj_idx), .cmd(cmd),
        .st_mask(st_mask), .st_arb(st_arb), .st_mctl(st_mctl), .st_data(st_data),
        .hd_mask(hd_mask), .hd_arb(hd_arb), .hd_mctl(hd_mctl), .hd_data(hd_data),
        .tx_vec(txrq_vec), .nd_vec(newdat_vec), .ip_vec(intpnd_vec)
    );
endmodule

// File: rtl/msgif_engine_chk.sv
module msgif_engine_chk #(
    parameter int NUM_OBJ = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [3:0]         wr_addr,
    input logic [15:0]        wr_data,
    input logic               busy,
    input logic [NUM_OBJ-1:0] txrq_vec,
    input logic [NUM_OBJ-1:0] newdat_vec,
    input logic [NUM_OBJ-1:0] intpnd_vec
);
    logic [3:0] run;
    logic       req, good_num;

    assign req      = wr_en && (wr_addr == 4'd0) && !busy;
    assign good_num = (wr_data >= 16'd1) && (wr_data <= 16'(NUM_OBJ));

    always_ff @(posedge clk) begin
        if (!rst_n)          run <= '0;
        else if (!busy)      run <= '0;
        else if (run != 4'hF) run <= run + 4'd1;
    end

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) run <= 4'd6); // R1
    AST_REQ_STARTS: assert property (@(posedge clk) disable iff (!rst_n) (req && good_num) |=> busy); // R1
    AST_BAD_NUM_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (req && !good_num) |=> !busy); // R2
    AST_ONE_OBJ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones((txrq_vec ^ $past(txrq_vec)) | (newdat_vec ^ $past(newdat_vec)) |
                   (intpnd_vec ^ $past(intpnd_vec))) <= 1); // R8
    AST_FLAGS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(txrq_vec) || !$stable(newdat_vec) || !$stable(intpnd_vec)) |-> $fell(busy)); // R6
endmodule

bind msgif_engine msgif_engine_chk #(.NUM_OBJ(NUM_OBJ)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .txrq_vec(txrq_vec), .newdat_vec(newdat_vec), .intpnd_vec(intpnd_vec)
);

// File: tb/sim_msgif_engine.sv
`timescale 1ns/1ps
module sim_msgif_engine;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [3:0]    rd_addr = '0;
    logic [15:0]   rd_data;
    logic          busy;
    logic [N-1:0]  txrq_vec, newdat_vec, intpnd_vec;
    logic [N-1:0]  m_tx = '0, m_nd = '0, m_ip = '0;
    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    msgif_engine #(.NUM_OBJ(N)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .txrq_vec(txrq_vec), .newdat_vec(newdat_vec), .intpnd_vec(intpnd_vec)
    );

    function automatic logic [31:0] pw(int n, int s);
        return 32'(n * 32'h01030507) ^ 32'(s * 32'h9E3779B9) ^ 32'h5A5A0000;
    endfunction
    function automatic logic [15:0] pc(int n, int s);
        return pw(n, s + 13) [15:0];
    endfunction
    function automatic logic [63:0] pd(int n, int s);
        return {pw(n, s + 21), pw(n, s + 29)};
    endfunction
    function automatic logic [7:0] gb(int g);
        logic [7:0] r = 8'h00;
        r[6] = g[4]; r[5] = g[3]; r[4] = g[2]; r[1] = g[1]; r[0] = g[0];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        rd_addr = a;
        #0.2;
        d = rd_data;
    endtask

    task automatic sput(input logic [31:0] m, input logic [31:0] a, input logic [15:0] c,
                        input logic [63:0] d);
        wr(4'd2, m[15:0]); wr(4'd3, m[31:16]);
        wr(4'd4, a[15:0]); wr(4'd5, a[31:16]);
        wr(4'd6, c);
        wr(4'd7, d[15:0]); wr(4'd8, d[31:16]); wr(4'd9, d[47:32]); wr(4'd10, d[63:48]);
    endtask

    task automatic sget(output logic [31:0] m, output logic [31:0] a, output logic [15:0] c,
                        output logic [63:0] d);
        logic [15:0] t;
        rd(4'd2, t); m[15:0] = t;  rd(4'd3, t); m[31:16] = t;
        rd(4'd4, t); a[15:0] = t;  rd(4'd5, t); a[31:16] = t;
        rd(4'd6, c);
        rd(4'd7, t); d[15:0] = t;  rd(4'd8, t); d[31:16] = t;
        rd(4'd9, t); d[47:32] = t; rd(4'd10, t); d[63:48] = t;
    endtask

    // bench flag model, updated from the requirements
    task automatic model(input int obj, input logic [7:0] cm, input logic [15:0] mc);
        if (cm[7]) begin
            if (cm[4]) begin
                m_tx[obj-1] = mc[8]; m_nd[obj-1] = mc[15]; m_ip[obj-1] = mc[13];
            end
            if (cm[2]) begin m_tx[obj-1] = 1'b1; m_nd[obj-1] = 1'b1; end
        end else begin
            if (cm[3]) m_ip[obj-1] = 1'b0;
            if (cm[2]) m_nd[obj-1] = 1'b0;
        end
    endtask

    task automatic cmd(input int obj, input logic [7:0] cm, input logic [15:0] mc);
        int n = 0;
        logic [15:0] q;
        wr(4'd1, {8'h00, cm});
        wr(4'd0, 16'(obj));
        chk("R1 busy raised", 64'(busy), 64'd1);
        rd(4'd0, q);
        chk("R1 request bit15 busy", 64'(q[15]), 64'd1);
        while (busy && n < 20) begin @(negedge clk); n++; end
        chk("R1 done within 6 clocks", 64'(n >= 1 && n <= 6), 64'd1);
        model(obj, cm, mc);
    endtask

    task automatic vecs(input string tag);
        chk({tag, " txrq"}, 64'(txrq_vec), 64'(m_tx));
        chk({tag, " newdat"}, 64'(newdat_vec), 64'(m_nd));
        chk({tag, " intpnd"}, 64'(intpnd_vec), 64'(m_ip));
    endtask

    function automatic logic [15:0] ovl(logic [15:0] raw, logic nd, logic ip, logic tx);
        return (raw & 16'h5EFF) | (16'(nd) << 15) | (16'(ip) << 13) | (16'(tx) << 8);
    endfunction

    initial begin
        logic [31:0] m, a;
        logic [15:0] c, q;
        logic [63:0] d;
        logic [31:0] zm, za;
        logic [15:0] zc;
        logic [63:0] zd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        chk("R9 busy", 64'(busy), 64'd0);
        vecs("R9");
        rd(4'd0, q); chk("R9 request reg", 64'(q), 64'd0);
        sget(m, a, c, d);
        chk("R9 staging", {m ^ a, c, 16'h0} | d, 64'd0);
        rd(4'd12, q); chk("R10 unmapped reads zero", 64'(q), 64'd0);
        sput(32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        cmd(20, 8'h73, 16'h0);
        sget(m, a, c, d);
        chk("R9 object cleared mask", 64'(m), 64'd0);
        chk("R9 object cleared arb", 64'(a), 64'd0);
        chk("R9 object cleared ctrl", 64'(c), 64'd0);
        chk("R9 object cleared data", d, 64'd0);

        // R4 R6 R8: full write of every object
        for (int n = 1; n <= N; n++) begin
            logic [7:0] cm;
            cm = (n % 3 == 0) ? 8'hF7 : 8'hF3;
            sput(pw(n, 0), pw(n, 3), pc(n, 0), pd(n, 0));
            cmd(n, cm, pc(n, 0));
            vecs("R6 R8 after write");
        end
        // R5 R8 R10: full read of every object
        for (int n = 1; n <= N; n++) begin
            sput('0, '0, '0, '0);
            cmd(n, 8'h73, 16'h0);
            sget(m, a, c, d);
            chk("R5 mask readback", 64'(m), 64'(pw(n, 0)));
            chk("R5 arb readback", 64'(a), 64'(pw(n, 3)));
            chk("R8 ctrl readback", 64'(c),
                64'(ovl(pc(n, 0), m_nd[n-1], m_ip[n-1], m_tx[n-1])));
            chk("R10 data readback", d, pd(n, 0));
        end
        vecs("R5 reads leave flags");

        // R4: exhaustive group sweep on write, object 7
        for (int g = 0; g < 32; g++) begin
            sput(pw(7, 1), pw(7, 4), pc(7, 1), pd(7, 1));
            cmd(7, 8'hF3, pc(7, 1));
            sput(pw(7, 2), pw(7, 5), pc(7, 2), pd(7, 2));
            cmd(7, 8'h80 | gb(g), pc(7, 2));
            sput('0, '0, '0, '0);
            cmd(7, 8'h73, 16'h0);
            sget(m, a, c, d);
            chk("R4 mask group", 64'(m), 64'(g[4] ? pw(7, 2) : pw(7, 1)));
            chk("R4 arb group", 64'(a), 64'(g[3] ? pw(7, 5) : pw(7, 4)));
            chk("R4 ctrl group", 64'(c), 64'(g[2] ? pc(7, 2) : pc(7, 1)));
            chk("R4 data lo group", 64'(d[31:0]), 64'(g[1] ? pd(7, 2) [31:0] : pd(7, 1) [31:0]));
            chk("R4 data hi group", 64'(d[63:32]), 64'(g[0] ? pd(7, 2) [63:32] : pd(7, 1) [63:32]));
        end

        // R5: exhaustive group sweep on read, object 10
        zm = pw(0, 9); za = pw(0, 10); zc = pc(0, 9); zd = pd(0, 9);
        for (int g = 0; g < 32; g++) begin
            sput(zm, za, zc, zd);
            cmd(10, gb(g), 16'h0);
            sget(m, a, c, d);
            chk("R5 mask group", 64'(m), 64'(g[4] ? pw(10, 0) : zm));
            chk("R5 arb group", 64'(a), 64'(g[3] ? pw(10, 3) : za));
            chk("R5 ctrl group", 64'(c), 64'(g[2] ? pc(10, 0) : zc));
            chk("R5 data lo group", 64'(d[31:0]), 64'(g[1] ? pd(10, 0) [31:0] : zd[31:0]));
            chk("R5 data hi group", 64'(d[63:32]), 64'(g[0] ? pd(10, 0) [63:32] : zd[63:32]));
        end

        // R7: read-side clears, object 3
        sput(pw(3, 7), pw(3, 8), 16'hA105, pd(3, 7));
        cmd(3, 8'hF3, 16'hA105);
        vecs("R8 flags loaded from ctrl");
        cmd(3, 8'h08, 16'h0);
        chk("R7 pending cleared", 64'(intpnd_vec[2]), 64'd0);
        chk("R7 newdat kept", 64'(newdat_vec[2]), 64'd1);
        vecs("R7 after clear pending");
        sput('0, '0, '0, '0);
        cmd(3, 8'h14, 16'h0);
        rd(4'd6, c);
        chk("R7 staging shows pre-clear flags", 64'(c), 64'h8105);
        chk("R7 newdat cleared", 64'(newdat_vec[2]), 64'd0);
        vecs("R7 after clear newdat");
        // R6: bit 2 without control group
        cmd(3, 8'h84, 16'h0);
        chk("R6 txrq set", 64'(txrq_vec[2]), 64'd1);
        chk("R6 newdat set", 64'(newdat_vec[2]), 64'd1);
        vecs("R6 no ctrl");

        // R2: invalid object numbers
        foreach (zc[i]) begin end
        for (int k = 0; k < 4; k++) begin
            logic [15:0] v;
            v = (k == 0) ? 16'd0 : (k == 1) ? 16'd33 : (k == 2) ? 16'd63 : 16'h8001;
            wr(4'd1, 16'h00F7);
            wr(4'd0, v);
            chk("R2 no busy", 64'(busy), 64'd0);
            @(negedge clk);
            chk("R2 still idle", 64'(busy), 64'd0);
            rd(4'd0, q);
            chk("R2 request reg keeps number", 64'(q), 64'd3);
            vecs("R2 flags unchanged");
        end

        // R3: second request while busy
        sput(pw(4, 11), pw(4, 12), pc(4, 11), pd(4, 11));
        wr(4'd1, 16'h00F3);
        wr(4'd0, 16'd4);
        wr(4'd0, 16'd5);
        chk("R3 done without restart", 64'(busy), 64'd0);
        rd(4'd0, q);
        chk("R3 request keeps first number", 64'(q), 64'd4);
        model(4, 8'hF3, pc(4, 11));
        vecs("R3 flags");
        cmd(5, 8'h73, 16'h0);
        sget(m, a, c, d);
        chk("R3 other object untouched mask", 64'(m), 64'(pw(5, 0)));
        chk("R3 other object untouched data", d, pd(5, 0));
        cmd(4, 8'h73, 16'h0);
        sget(m, a, c, d);
        chk("R3 first object written", 64'(a), 64'(pw(4, 12)));

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule